// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Port

This block is the host-facing register port of a character display controller. A host processor reaches it over an asynchronous parallel bus. A static pin selects one of two signalling styles. In the first style, one line gives direction and a second line is an enable strobe. In the second style, there are separate active-low write and read strobes. Chip select and register select are resampled into the system clock domain. Each completed host cycle becomes a one-cycle pulse on the trailing edge of its strobe. A write becomes either an instruction byte or a data byte for the logic downstream.

Reads come from two sources. A read with register select low returns a status word whose top bit is the busy flag. A read with register select high returns an output register, and then asks a synchronous RAM port for the next byte. The host therefore always receives the byte fetched by its previous data read. This makes the first data read after an address change a dummy. The data path can be eight bits wide or four bits wide. The width is chosen by a width bit, which the port decodes itself from instruction writes. In the narrow path each byte moves as two nibbles on the upper four lanes, high nibble first, for writes and for reads.

Top module: `dual_bus_host_port`

## Requirements
- R1: With `mode_m68` high, `rw_wr` high means read and low means write, `e_rd` is an active-high enable, and a transfer completes on the falling edge of `e_rd`. With `mode_m68` low, `rw_wr` is an active-low write strobe and `e_rd` is an active-low read strobe, and a transfer completes on the rising edge of its strobe.
- R2: While `cs_n` is high, strobes produce no write pulse and no RAM fetch, and `dout_en` stays low.
- R3: A completed write with `rs` low pulses `ir_wr` with the byte on `ir_data`. With `rs` high it pulses `dr_wr` with the byte on `dr_data`. The two pulses are never high together.
- R4: Each write pulse and each fetch request lasts one clock cycle. It is visible after the third rising clock edge that follows the strobe reaching its trailing level.
- R5: `dout_en` is high exactly while `cs_n` is low and the read condition of the selected signalling style holds on the pins.
- R6: A read with `rs` low returns the status word {`busy_in`, seven zeros}, with the busy flag in bit 7. It does not request a RAM fetch.
- R7: A read with `rs` high returns the output register, which is zero after reset. When the byte completes, the port pulses `ram_rd_req`. The output register loads `ram_rd_data` on the second rising edge after `ram_rd_req` is seen high. As a result, the first data read after the RAM address moves returns the previously fetched byte.
- R8: After reset the path is eight bits wide (`wide_mode` = 1). A completed instruction byte whose bits 7:5 equal 001 sets `wide_mode` to its bit 4.
- R9: In the narrow path only `din[7:4]` is used. A written byte is the first nibble (high) followed by the second nibble (low), and its pulse comes only after the second nibble.
- R10: In the narrow path a read returns bits 7:4 of the value on `dout[7:4]` for the first nibble and bits 3:0 for the second, with `dout[3:0]` zero. The RAM fetch follows only the second nibble, so a dummy read spans two nibble reads.
- R11: The nibble phase is at "high" after reset and after every change of `wide_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_m68 | input | 1 | Static bus style select: 1 = direction plus enable, 0 = separate strobes |
| cs_n | input | 1 | Active-low chip select |
| rs | input | 1 | Register select: 0 = instruction/status, 1 = data |
| rw_wr | input | 1 | Direction line (mode 1) or active-low write strobe (mode 0) |
| e_rd | input | 1 | Enable strobe (mode 1) or active-low read strobe (mode 0) |
| din | input | 8 | Host data into the port |
| dout | output | 8 | Read data toward the host |
| dout_en | output | 1 | Drive enable for the host data bus |
| busy_in | input | 1 | Busy flag from the instruction execution logic |
| ram_rd_data | input | 8 | Synchronous RAM read data, valid the cycle after a request |
| ir_wr | output | 1 | One-cycle instruction write pulse |
| ir_data | output | 8 | Instruction byte |
| dr_wr | output | 1 | One-cycle data write pulse |
| dr_data | output | 8 | Data byte |
| ram_rd_req | output | 1 | One-cycle fetch request, also advances the address counter |
| wide_mode | output | 1 | Current data path width: 1 = eight bits |

## Verification
A nibble phase that has slipped shows up at the very next narrow transfer. A write pulse appears after one nibble instead of two, or a read presents the wrong half of the byte on `dout[7:4]` while the strobe is still held. A stale or early refill of the output register shows on the next data read. A missed or extra fetch then shifts every later read by one RAM address, and that shift persists. The bench checks `dout_en` against the pins on every clock. A mismatch in strobe qualification therefore shows within a cycle, while pulse timing is checked at the exact cycle given in R4.

// File: rtl/hostif_pkg.sv
package hostif_pkg;
  localparam int BUS_W = 8;
  localparam int NIB_W = BUS_W / 2;
  localparam logic [2:0] WIDTH_OPC = 3'b001;
  localparam int WIDTH_BIT = 4;

  // Write condition of the selected signalling style.
  function automatic logic wr_strobe(input logic m68, input logic cs_n,
                                     input logic rw, input logic en);
    return !cs_n && (m68 ? (en && !rw) : !rw);
  endfunction

  // Read condition of the selected signalling style.
  function automatic logic rd_strobe(input logic m68, input logic cs_n,
                                     input logic rw, input logic en);
    return !cs_n && (m68 ? (en && rw) : !en);
  endfunction

  // Place the current half of a byte on the upper lanes in narrow mode.
  function automatic logic [BUS_W-1:0] lane_view(input logic [BUS_W-1:0] v,
                                                 input logic wide, input logic lo);
    if (wide) return v;
    if (lo) return {v[NIB_W-1:0], {NIB_W{1'b0}}};
    return {v[BUS_W-1:NIB_W], {NIB_W{1'b0}}};
  endfunction

  function automatic logic [BUS_W-1:0] status_word(input logic busy);
    return {busy, {(BUS_W-1){1'b0}}};
  endfunction

  function automatic logic is_width_cmd(input logic [BUS_W-1:0] b);
    return b[BUS_W-1 -: 3] == WIDTH_OPC;
  endfunction
endpackage

// File: rtl/hostif_sync.sv
module hostif_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hostif_strobe.sv
module hostif_strobe
  import hostif_pkg::*;
#(
  parameter int W = BUS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         m68,
  input  logic         cs_n_s,
  input  logic         rs_s,
  input  logic         rw_s,
  input  logic         en_s,
  input  logic [W-1:0] din_s,
  output logic         wr_done,
  output logic         rd_done,
  output logic         rs_h,
  output logic [W-1:0] din_h
);
  logic wr_act, rd_act, wr_q, rd_q;

  assign wr_act = wr_strobe(m68, cs_n_s, rw_s, en_s);
  assign rd_act = rd_strobe(m68, cs_n_s, rw_s, en_s);

  // Trailing edge of a qualified strobe.
  assign wr_done = wr_q && !wr_act;
  assign rd_done = rd_q && !rd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
      rs_h  <= 1'b0;
      din_h <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_act || rd_act) begin
        rs_h  <= rs_s;
        din_h <= din_s;
      end
    end
  end
endmodule

// File: rtl/hostif_nibble.sv
module hostif_nibble
  import hostif_pkg::*;
#(
  parameter int W = BUS_W,
  parameter int H = NIB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         xfer_wr,
  input  logic         xfer_rd,
  input  logic         rs_h,
  input  logic [W-1:0] din_h,
  output logic         wide,
  output logic         lo_phase,
  output logic         byte_wr,
  output logic         byte_rd,
  output logic [W-1:0] byte_val
);
  logic [H-1:0] hi_q;
  logic         width_hit;
  logic         wide_next;

  assign byte_wr  = xfer_wr && (wide || lo_phase);
  assign byte_rd  = xfer_rd && (wide || lo_phase);
  assign byte_val = wide ? din_h : {hi_q, din_h[W-1 -: H]};

  assign width_hit = byte_wr && !rs_h && is_width_cmd(byte_val);
  assign wide_next = width_hit ? byte_val[WIDTH_BIT] : wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide     <= 1'b1;
      lo_phase <= 1'b0;
      hi_q     <= '0;
    end else begin
      wide <= wide_next;
      if (xfer_wr && !wide && !lo_phase) hi_q <= din_h[W-1 -: H];
      if (wide_next != wide)                       lo_phase <= 1'b0;
      else if ((xfer_wr || xfer_rd) && !wide)      lo_phase <= !lo_phase;
    end
  end

  // R9: a high nibble write always leaves the phase on the low nibble
  assert_hi_then_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_wr && !wide && !lo_phase) |=> lo_phase);

  // R11: a width change returns the phase to the high nibble
  assert_phase_home_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wide) |-> !lo_phase);
endmodule

// File: rtl/dual_bus_host_port.sv
module dual_bus_host_port
  import hostif_pkg::*;
#(
  parameter int W = BUS_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_m68,
  input  logic         cs_n,
  input  logic         rs,
  input  logic         rw_wr,
  input  logic         e_rd,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dout_en,
  input  logic         busy_in,
  input  logic [W-1:0] ram_rd_data,
  output logic         ir_wr,
  output logic [W-1:0] ir_data,
  output logic         dr_wr,
  output logic [W-1:0] dr_data,
  output logic         ram_rd_req,
  output logic         wide_mode
);
  localparam int PW = W + 4;
  localparam logic [PW-1:0] PIN_IDLE = {1'b1, {(PW-1){1'b0}}};

  logic [PW-1:0] pins_s;
  logic          cs_n_s, rs_s, rw_s, en_s;
  logic [W-1:0]  din_s;
  logic          wr_done, rd_done, rs_h;
  logic [W-1:0]  din_h;
  logic          lo_phase, byte_wr, byte_rd;
  logic [W-1:0]  byte_val;
  logic          fetch_pend;
  logic [W-1:0]  out_reg;
  logic [W-1:0]  rd_value;

  hostif_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d ({cs_n, rs, rw_wr, e_rd, din}),
    .q (pins_s)
  );
  assign {cs_n_s, rs_s, rw_s, en_s, din_s} = pins_s;

  hostif_strobe #(.W(W)) u_strobe (
    .clk (clk),
    .rst_n (rst_n),
    .m68 (mode_m68),
    .cs_n_s (cs_n_s),
    .rs_s (rs_s),
    .rw_s (rw_s),
    .en_s (en_s),
    .din_s (din_s),
    .wr_done (wr_done),
    .rd_done (rd_done),
    .rs_h (rs_h),
    .din_h (din_h)
  );

  hostif_nibble #(.W(W), .H(W/2)) u_nibble (
    .clk (clk),
    .rst_n (rst_n),
    .xfer_wr (wr_done),
    .xfer_rd (rd_done),
    .rs_h (rs_h),
    .din_h (din_h),
    .wide (wide_mode),
    .lo_phase (lo_phase),
    .byte_wr (byte_wr),
    .byte_rd (byte_rd),
    .byte_val (byte_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_wr      <= 1'b0;
      dr_wr      <= 1'b0;
      ir_data    <= '0;
      dr_data    <= '0;
      ram_rd_req <= 1'b0;
      fetch_pend <= 1'b0;
      out_reg    <= '0;
    end else begin
      ir_wr      <= byte_wr && !rs_h;
      dr_wr      <= byte_wr && rs_h;
      ram_rd_req <= byte_rd && rs_h;
      fetch_pend <= ram_rd_req;
      if (byte_wr && !rs_h) ir_data <= byte_val;
      if (byte_wr && rs_h)  dr_data <= byte_val;
      if (fetch_pend)       out_reg <= ram_rd_data;
    end
  end

  // Bus drive follows the pins directly so the host sees data in its own cycle.
  assign rd_value = rs ? out_reg : status_word(busy_in);
  assign dout     = lane_view(rd_value, wide_mode, lo_phase);
  assign dout_en  = rd_strobe(mode_m68, cs_n, rw_wr, e_rd);

  // R2: a deselected port never drives the bus
  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !dout_en);

  // R3: instruction and data pulses are exclusive
  assert_ir_dr_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ir_wr && dr_wr));

  // R4: write pulses last one cycle
  assert_ir_one_shot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |=> !ir_wr);
  assert_dr_one_shot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dr_wr |=> !dr_wr);

  // R7: one fetch per completed data byte
  assert_fetch_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_req |=> !ram_rd_req);

  // R10: lower lanes are zero in the narrow path
  assert_low_lanes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && !wide_mode) |-> (dout[W/2-1:0] == '0));
endmodule

// File: tb/dual_bus_host_port_tb.sv
module dual_bus_host_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m68 = 1'b1;
  logic       b_cs_n = 1'b1, b_rs = 1'b0, b_rw = 1'b1, b_e = 1'b0;
  logic [7:0] b_din = 8'h00;
  logic [7:0] dout;
  logic       dout_en;
  logic       busy = 1'b0;
  logic [7:0] ram_q = 8'h00;
  logic       ir_wr, dr_wr, ram_rd_req, wide_mode;
  logic [7:0] ir_data, dr_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] mem [16];
  int         ram_ptr = 0;

  // model state
  bit         exp_wide = 1;
  bit         exp_lo = 0;
  logic [3:0] exp_hi = 4'h0;
  logic [7:0] exp_or = 8'h00;

  always #2.5 clk = ~clk;

  dual_bus_host_port u_dut (
    .clk (clk), .rst_n (rst_n), .mode_m68 (m68),
    .cs_n (b_cs_n), .rs (b_rs), .rw_wr (b_rw), .e_rd (b_e),
    .din (b_din), .dout (dout), .dout_en (dout_en), .busy_in (busy),
    .ram_rd_data (ram_q), .ir_wr (ir_wr), .ir_data (ir_data),
    .dr_wr (dr_wr), .dr_data (dr_data), .ram_rd_req (ram_rd_req),
    .wide_mode (wide_mode)
  );

  // synchronous RAM with a self-advancing address
  always @(posedge clk)
    if (ram_rd_req) begin
      ram_q = mem[ram_ptr];
      ram_ptr = (ram_ptr + 1) % 16;
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  // R5: bus drive enable compared against the pins every clock
  always @(negedge clk) begin
    bit want;
    if (m68) want = !b_cs_n && b_e && b_rw;
    else     want = !b_cs_n && !b_e;
    if (!finished) chk(dout_en == want, "R5 dout_en", dout_en, want);
  end

  function automatic logic [7:0] view(input logic [7:0] x, input bit wide, input bit lo);
    if (wide) return x;
    if (lo)   return (x << 4) & 8'hF0;
    return x & 8'hF0;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input bit cs_on, input bit r, input bit rd, input logic [7:0] v,
                      input string req);
    bit         done_b, ir_e, dr_e, rq_e, wide_n;
    logic [7:0] byte_v, view_e, next_or;
    done_b = cs_on && (exp_wide || exp_lo);
    byte_v = exp_wide ? v : {exp_hi, v[7:4]};
    view_e = view(r ? exp_or : {busy, 7'b0}, exp_wide, exp_lo);
    ir_e = done_b && !rd && !r;
    dr_e = done_b && !rd && r;
    rq_e = done_b && rd && r;
    next_or = exp_or;
    @(negedge clk);
    b_cs_n = !cs_on; b_rs = r; b_din = v;
    if (m68) b_rw = rd;
    @(negedge clk);
    if (m68) b_e = 1'b1;
    else if (rd) b_e = 1'b0;
    else b_rw = 1'b0;
    repeat (3) @(negedge clk);
    if (rd) begin
      chk(dout_en == cs_on, {req, " read enable"}, dout_en, cs_on);
      if (cs_on) chk(dout == view_e, {req, " read data"}, dout, view_e);
    end
    if (m68) b_e = 1'b0;
    else begin b_e = 1'b1; b_rw = 1'b1; end
    repeat (3) @(negedge clk);
    chk(ir_wr == ir_e, {req, " ir_wr pulse"}, ir_wr, ir_e);
    chk(dr_wr == dr_e, {req, " dr_wr pulse"}, dr_wr, dr_e);
    chk(ram_rd_req == rq_e, {req, " fetch pulse"}, ram_rd_req, rq_e);
    if (ir_e) chk(ir_data == byte_v, {req, " ir_data"}, ir_data, byte_v);
    if (dr_e) chk(dr_data == byte_v, {req, " dr_data"}, dr_data, byte_v);
    wide_n = exp_wide;
    if (ir_e && byte_v[7:5] == 3'b001) wide_n = byte_v[4];
    chk(wide_mode == wide_n, {req, " width"}, wide_mode, wide_n);
    if (rq_e) next_or = mem[ram_ptr];
    if (cs_on && !exp_wide) begin
      if (!exp_lo && !rd) exp_hi = v[7:4];
      exp_lo = !exp_lo;
    end
    if (wide_n != exp_wide) exp_lo = 0;
    exp_wide = wide_n;
    @(negedge clk);
    chk(!ir_wr && !dr_wr && !ram_rd_req, {req, " pulse width"},
        {ir_wr, dr_wr, ram_rd_req}, 0);
    b_cs_n = 1'b1;
    if (m68) b_rw = 1'b1;
    idle(5);
    exp_or = next_or;
  endtask

  task automatic put_byte(input bit r, input logic [7:0] v, input string req);
    if (exp_wide) xfer(1, r, 0, v, req);
    else begin
      xfer(1, r, 0, {v[7:4], 4'hA}, req);
      xfer(1, r, 0, {v[3:0], 4'h5}, req);
    end
  endtask

  task automatic get_byte(input bit r, input string req);
    if (exp_wide) xfer(1, r, 1, 8'h00, req);
    else begin
      xfer(1, r, 1, 8'h00, req);
      xfer(1, r, 1, 8'h00, req);
    end
  endtask

  task automatic do_reset(input bit mode);
    rst_n = 1'b0;
    m68 = mode;
    b_cs_n = 1'b1; b_rs = 1'b0; b_rw = 1'b1; b_e = mode ? 1'b0 : 1'b1;
    exp_wide = 1; exp_lo = 0; exp_hi = 4'h0; exp_or = 8'h00;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    // R8 R11: reset state
    chk(wide_mode == 1'b1, "R8 reset width", wide_mode, 1);
    chk(!ir_wr && !dr_wr && !ram_rd_req, "R4 reset pulses", {ir_wr, dr_wr, ram_rd_req}, 0);
    chk(dout_en == 1'b0, "R2 reset drive", dout_en, 0);
  endtask

  task automatic run_suite(input bit mode);
    do_reset(mode);
    put_byte(0, 8'h5A, "R1 R3 instr write");
    put_byte(1, 8'hC3, "R3 data write");
    xfer(0, 1, 0, 8'h77, "R2 deselected write");
    xfer(0, 1, 1, 8'h00, "R2 deselected read");
    busy = 1'b1;
    get_byte(0, "R6 busy high");
    busy = 1'b0;
    get_byte(0, "R6 busy low");
    ram_ptr = 4;
    get_byte(1, "R7 dummy read");
    get_byte(1, "R7 first valid read");
    get_byte(1, "R7 second valid read");
    put_byte(0, 8'h20, "R8 to narrow");
    put_byte(1, 8'h9E, "R9 R11 narrow data write");
    put_byte(0, 8'h47, "R9 narrow instr write");
    ram_ptr = 9;
    get_byte(1, "R10 narrow dummy");
    get_byte(1, "R10 narrow valid");
    busy = 1'b1;
    get_byte(0, "R10 R6 narrow busy");
    busy = 1'b0;
    xfer(0, 1, 0, 8'hF0, "R2 narrow deselected");
    put_byte(0, 8'h30, "R8 R11 back to wide");
    put_byte(1, 8'h6B, "R11 wide after narrow");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'(i * 29 + 7);
    run_suite(1'b1);
    run_suite(1'b0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule